// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour), day of month, weekday, month and a two-digit year that stands for 2000 to 2099. A prescaler counts a low-rate oscillator enable (32768 pulses per second by default) down to a one-second tick. That tick advances a carry chain which knows month lengths and leap years. A control bit holds the prescaler in reset, so that a newly written time starts on a clean second boundary.

Software reaches the registers through a byte-wide port inside an access window. While the window is open the time registers are frozen, so a multi-byte read returns one coherent instant. A second that falls due inside the window is remembered and applied once, on the first cycle after the window closes. A flag in the top bit of the seconds byte records that the oscillator has not run since power-up. It is cleared by any write of the seconds byte.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the control byte (offset 0x0) reads 0x00, seconds reads 0x80 (oscillator-stop flag set, value 00), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 and year 0x00.
- R2: Seconds advances by one exactly on the PRESC_DIV-th enable pulse. Writing the seconds byte (offset 0x4, value in bits 6:0) clears the flag in bit 7.
- R3: Seconds, minutes and hours count in BCD and carry at 59, 59 and 23. Minutes is offset 0x5 (bits 6:0) and hours is offset 0x6 (bits 5:0). A units digit of 9 carries into the tens digit.
- R4: Day (offset 0x7, bits 5:0) wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days, February has 29 days when the BCD year's value is divisible by 4 and 28 otherwise, and all other months have 31 days.
- R5: Month (offset 0x9, bits 4:0) wraps from 12 to 01 and increments the year (offset 0xA, 8 bits). Year wraps from 99 to 00.
- R6: Weekday (offset 0x8, binary in bits 2:0) increments modulo 7 on every day rollover, independent of the date.
- R7: While the access window is open the time registers change only by writes. Any number of seconds falling due in the window are applied as one increment on the cycle after it closes.
- R8: While control bit 5 is 1, the prescaler is held at zero and time does not advance. After the bit is cleared, the next second falls on the PRESC_DIV-th enable pulse.
- R9: Unused bits of each byte read 0. Writes to unmapped offsets are discarded, and unmapped offsets read 0x00.
- R10: Writes presented while the access window is closed are ignored, and reads outside the window return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| bus_hold | input | 1 | Access window open; freezes the time registers |
| wr_en | input | 1 | Byte write strobe, valid inside the window |
| rd_en | input | 1 | Byte read strobe, valid inside the window |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, combinational from the addressed register |

## Verification
The bench drives the calendar up to each rollover boundary: the end of 30-day and 31-day months, February in years 23, 24, 12 and 10, and December 31 of year 99. Year 10 catches a leap test done on the raw hex byte (0x10 is divisible by 4), which would wrongly produce February 29. It opens the access window across one and across two seconds' worth of pulses. A design that drops the deferred tick stays one second behind, and one that queues both ticks jumps two. It starts and then clears the stop bit after a partial second. A prescaler that keeps its residue would advance early, on the fifth pulse instead of the eighth.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int CTRL_OFS  = 0;
   localparam int TIME_OFS  = 4;
   localparam int HALT_BIT  = 5;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [5:0] day;
      logic [2:0] wday;
      logic [4:0] mon;
      logic [7:0] year;
   } rtc_time_t;

   localparam rtc_time_t TIME_RST = '{sec: 7'h00, min: 7'h00, hour: 6'h00,
                                      day: 6'h01, wday: 3'd0, mon: 5'h01,
                                      year: 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // value of the two BCD digits divisible by 4
   function automatic logic bcd_leap(input logic [7:0] y);
      logic [3:0] lo;
      lo = y[3:0];
      if (y[4]) return (lo == 4'd2) || (lo == 4'd6);
      else      return (lo == 4'd0) || (lo == 4'd4) || (lo == 4'd8);
   endfunction

   function automatic logic [5:0] month_last(input logic [4:0] m, input logic leap);
      case (m)
         5'h02:                      return leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int  CW  = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam bit  POW2 = (DIV & (DIV - 1)) == 0;

   logic [CW-1:0] cnt_q;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("rtc_prescaler: DIV must be at least 2");
      end
      if (POW2) begin : g_pow2
         // counter wraps on its own at a power of two
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)    cnt_q <= '0;
            else if (clr)  cnt_q <= '0;
            else if (en)   cnt_q <= cnt_q + 1'b1;
         assign tick = en && !clr && (&cnt_q);
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)    cnt_q <= '0;
            else if (clr)  cnt_q <= '0;
            else if (en)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         assign tick = en && !clr && (cnt_q == LAST);
      end
   endgenerate

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2

endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
   import rtc_cal_pkg::*;
(
   input  rtc_time_t cur,
   output rtc_time_t nxt,
   output logic      day_wrap
);
   logic       s_wrap, m_wrap, h_wrap, mo_wrap;
   logic [5:0] last_day;
   logic [7:0] s_inc, m_inc, h_inc, d_inc, mo_inc, y_inc;

   always_comb begin
      last_day = month_last(cur.mon, bcd_leap(cur.year));
      s_wrap   = cur.sec  >= 7'h59;
      m_wrap   = s_wrap && (cur.min  >= 7'h59);
      h_wrap   = m_wrap && (cur.hour >= 6'h23);
      day_wrap = h_wrap;
      mo_wrap  = h_wrap && (cur.day >= last_day);

      s_inc  = bcd_inc({1'b0, cur.sec});
      m_inc  = bcd_inc({1'b0, cur.min});
      h_inc  = bcd_inc({2'b0, cur.hour});
      d_inc  = bcd_inc({2'b0, cur.day});
      mo_inc = bcd_inc({3'b0, cur.mon});
      y_inc  = bcd_inc(cur.year);

      nxt = cur;
      nxt.sec = s_wrap ? 7'h00 : s_inc[6:0];
      if (s_wrap) nxt.min  = m_wrap ? 7'h00 : m_inc[6:0];
      if (m_wrap) nxt.hour = h_wrap ? 6'h00 : h_inc[5:0];
      if (h_wrap) begin
         nxt.day  = mo_wrap ? 6'h01 : d_inc[5:0];
         nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
      end
      if (mo_wrap) begin
         nxt.mon = (cur.mon >= 5'h12) ? 5'h01 : mo_inc[4:0];
         if (cur.mon >= 5'h12)
            nxt.year = (cur.year >= 8'h99) ? 8'h00 : y_inc;
      end
   end

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
   import rtc_cal_pkg::*;
#(
   parameter int PRESC_DIV = 32768,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic              bus_hold,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int LAST_OFS = TIME_OFS + 6;

   generate
      if (ADDR_W < 4) begin : g_bad_aw
         $error("rtc_bcd_core: ADDR_W too small for the register map");
      end
   endgenerate

   rtc_time_t time_q, time_nxt;
   logic      osf_q, halt_q, pend_q;
   logic      sec_tick, apply, wr_ok, day_wrap;

   rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (halt_q),
      .en   (osc_en),
      .tick (sec_tick)
   );

   rtc_cal_next u_cal (
      .cur     (time_q),
      .nxt     (time_nxt),
      .day_wrap(day_wrap)
   );

   assign wr_ok = wr_en && bus_hold;
   assign apply = (sec_tick || pend_q) && !bus_hold && !halt_q;

   // tick deferred while the window is open, at most one kept
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        pend_q <= 1'b0;
      else if (halt_q)   pend_q <= 1'b0;
      else if (bus_hold) pend_q <= pend_q || sec_tick;
      else               pend_q <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         time_q <= TIME_RST;
         osf_q  <= 1'b1;
         halt_q <= 1'b0;
      end else if (wr_ok) begin
         case (int'(addr))
            CTRL_OFS:     halt_q       <= wdata[HALT_BIT];
            TIME_OFS:     begin time_q.sec <= wdata[6:0]; osf_q <= 1'b0; end
            TIME_OFS + 1: time_q.min  <= wdata[6:0];
            TIME_OFS + 2: time_q.hour <= wdata[5:0];
            TIME_OFS + 3: time_q.day  <= wdata[5:0];
            TIME_OFS + 4: time_q.wday <= wdata[2:0];
            TIME_OFS + 5: time_q.mon  <= wdata[4:0];
            LAST_OFS:     time_q.year <= wdata;
            default: ;
         endcase
      end else if (apply) begin
         time_q <= time_nxt;
      end

   logic [7:0] rmux;
   always_comb begin
      case (int'(addr))
         CTRL_OFS:     rmux = 8'(halt_q) << HALT_BIT;
         TIME_OFS:     rmux = {osf_q, time_q.sec};
         TIME_OFS + 1: rmux = {1'b0, time_q.min};
         TIME_OFS + 2: rmux = {2'b0, time_q.hour};
         TIME_OFS + 3: rmux = {2'b0, time_q.day};
         TIME_OFS + 4: rmux = {5'b0, time_q.wday};
         TIME_OFS + 5: rmux = {3'b0, time_q.mon};
         LAST_OFS:     rmux = time_q.year;
         default:      rmux = 8'h00;
      endcase
   end
   assign rdata = (rd_en && bus_hold) ? rmux : 8'h00;

   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hold && !wr_en) |=> $stable(time_q)); // R7

   AST_PEND_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !bus_hold) |=> !pend_q); // R7

   AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> !sec_tick); // R8

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !wr_ok) |=> $stable(time_q)); // R8

   AST_WDAY_WITH_DAY: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> ((time_q.wday != $past(time_q.wday)) == (time_q.day != $past(time_q.day)))); // R6

   AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_hold && !apply) |=> ($stable(time_q) && $stable(halt_q))); // R10

endmodule

// File: tb/sim_rtc_bcd_core.sv
`timescale 1ns/1ps
module sim_rtc_bcd_core;
   localparam int DIV = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en = 1'b0, bus_hold = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   rtc_bcd_core #(.PRESC_DIV(DIV), .ADDR_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_hold(bus_hold),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   // monitor: compare each read against the scoreboard
   always @(negedge clk) begin
      if (rd_en) begin
         exp_t e;
         n_tests++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read addr=%0h actual=%02h expected=none", addr, rdata);
         end else begin
            e = sb_q.pop_front();
            if (rdata !== e.exp) begin
               n_fail++;
               $display("FAIL %s addr=%0h actual=%02h expected=%02h", e.tag, addr, rdata, e.exp);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk); #2;
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic open_win();
      step(); bus_hold = 1'b1;
   endtask

   task automatic close_win();
      step(); bus_hold = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      step(); wr_en = 1'b1; addr = a; wdata = d;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      exp_t it;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      step(); rd_en = 1'b1; addr = a;
   endtask

   task automatic pulse(input int n);
      repeat (n) begin @(posedge clk); #2; wr_en = 1'b0; rd_en = 1'b0; osc_en = 1'b1; end
      @(posedge clk); #2; osc_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] s, m, h, d, w, mo, y);
      open_win();
      wr(4'h4, s); wr(4'h5, m); wr(4'h6, h); wr(4'h7, d);
      wr(4'h8, w); wr(4'h9, mo); wr(4'hA, y);
      close_win();
   endtask

   task automatic chk_time(input logic [7:0] s, m, h, d, w, mo, y, input string tag);
      open_win();
      rd(4'h4, s, tag); rd(4'h5, m, tag); rd(4'h6, h, tag); rd(4'h7, d, tag);
      rd(4'h8, w, tag); rd(4'h9, mo, tag); rd(4'hA, y, tag);
      close_win();
   endtask

   task automatic chk_one(input logic [3:0] a, input logic [7:0] e, input string tag);
      open_win(); rd(a, e, tag); close_win();
   endtask

   // roll one second from 23:59:59 of the given date
   task automatic roll_day(input logic [7:0] d, w, mo, y, d2, w2, mo2, y2, input string tag);
      set_time(8'h59, 8'h59, 8'h23, d, w, mo, y);
      pulse(DIV);
      chk_time(8'h00, 8'h00, 8'h00, d2, w2, mo2, y2, tag);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset values, R9 unmapped read
      chk_time(8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, "R1");
      chk_one(4'h0, 8'h00, "R1");
      chk_one(4'hB, 8'h00, "R9");

      // R2 one second per DIV pulses; seconds write clears flag
      pulse(DIV - 1);
      chk_one(4'h4, 8'h80, "R2");
      pulse(1);
      chk_one(4'h4, 8'h81, "R2");
      open_win(); wr(4'h4, 8'h30); rd(4'h4, 8'h30, "R2"); close_win();

      // R3 BCD digit carry and time carry chain
      set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
      pulse(DIV);
      chk_one(4'h4, 8'h10, "R3");
      roll_day(8'h15, 8'h03, 8'h06, 8'h24, 8'h16, 8'h04, 8'h06, 8'h24, "R3");

      // R4 month lengths and leap years
      roll_day(8'h28, 8'h01, 8'h02, 8'h23, 8'h01, 8'h02, 8'h03, 8'h23, "R4");
      roll_day(8'h28, 8'h01, 8'h02, 8'h10, 8'h01, 8'h02, 8'h03, 8'h10, "R4");
      roll_day(8'h28, 8'h01, 8'h02, 8'h24, 8'h29, 8'h02, 8'h02, 8'h24, "R4");
      roll_day(8'h29, 8'h02, 8'h02, 8'h24, 8'h01, 8'h03, 8'h03, 8'h24, "R4");
      roll_day(8'h28, 8'h00, 8'h02, 8'h12, 8'h29, 8'h01, 8'h02, 8'h12, "R4");
      roll_day(8'h30, 8'h04, 8'h04, 8'h31, 8'h01, 8'h05, 8'h05, 8'h31, "R4");
      roll_day(8'h30, 8'h04, 8'h01, 8'h31, 8'h31, 8'h05, 8'h01, 8'h31, "R4");

      // R5 end of year and century wrap
      roll_day(8'h31, 8'h05, 8'h12, 8'h99, 8'h01, 8'h06, 8'h01, 8'h00, "R5");
      roll_day(8'h31, 8'h05, 8'h12, 8'h19, 8'h01, 8'h06, 8'h01, 8'h20, "R5");

      // R6 weekday modulo 7
      roll_day(8'h10, 8'h06, 8'h03, 8'h05, 8'h11, 8'h00, 8'h03, 8'h05, "R6");

      // R7 freeze during window, deferred tick applied once
      set_time(8'h10, 8'h20, 8'h08, 8'h05, 8'h02, 8'h07, 8'h30);
      open_win(); pulse(DIV); rd(4'h4, 8'h10, "R7"); close_win();
      chk_one(4'h4, 8'h11, "R7");
      open_win(); pulse(2 * DIV); rd(4'h4, 8'h11, "R7"); close_win();
      chk_time(8'h12, 8'h20, 8'h08, 8'h05, 8'h02, 8'h07, 8'h30, "R7");

      // R8 stop bit holds prescaler; fresh second after release
      pulse(3);
      open_win(); wr(4'h0, 8'hFF); rd(4'h0, 8'h20, "R8"); close_win();
      pulse(3 * DIV);
      chk_one(4'h4, 8'h12, "R8");
      open_win(); wr(4'h0, 8'h00); close_win();
      pulse(DIV - 1);
      chk_one(4'h4, 8'h12, "R8");
      pulse(1);
      chk_one(4'h4, 8'h13, "R8");

      // R9 masks and unmapped offsets
      open_win();
      wr(4'hC, 8'hFF); rd(4'hC, 8'h00, "R9");
      wr(4'h5, 8'hFF); rd(4'h5, 8'h7F, "R9");
      wr(4'h6, 8'hFF); rd(4'h6, 8'h3F, "R9");
      wr(4'h8, 8'hFF); rd(4'h8, 8'h07, "R9");
      wr(4'h9, 8'hFF); rd(4'h9, 8'h1F, "R9");
      close_win();

      // R10 write and read outside the window
      step(); wr_en = 1'b1; addr = 4'h5; wdata = 8'h33;
      step();
      chk_one(4'h5, 8'h7F, "R10");
      begin
         exp_t it;
         it.exp = 8'h00; it.tag = "R10";
         sb_q.push_back(it);
         step(); rd_en = 1'b1; addr = 4'h5;
         step();
      end

      repeat (3) @(posedge clk);
      if (sb_q.size() != 0) begin
         n_fail++;
         $display("FAIL R1 reads outstanding actual=%0d expected=0", sb_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule